// File: doc/BRIEF.md
# Bidirectional-Bus Universal Shift Register

This block keeps a WIDTH-bit register (eight bits by default). On each rising clock edge, a two-bit mode select chooses one of four actions. The register can hold its value, shift toward the high end, shift toward the low end, or load a whole word in parallel. Parallel data moves over one shared bidirectional bus.

The block drives its register value onto that bus through tristate drivers. During a parallel load it samples the bus instead. The drivers turn off when either of two active-low enables is high. They also turn off on their own whenever load mode is selected, so an outside source can drive the bus without contention.

The lowest and highest register bits always appear on two dedicated serial outputs. Several blocks can therefore be chained into longer words. An active-low reset clears the register at once, without waiting for a clock edge.

Top module: `usr_shift_top`

## Requirements
- R1: While rstN is low, every register bit reads 0 at once, with no clock edge needed. Clock edges and the mode select have no effect during reset.
- R2: modeSel=2'b11 (load): at the rising edge, the register takes the value on dataBus, bus bit n into register bit n.
- R3: modeSel=2'b01 (shift up): at the rising edge, serInRight enters bit 0, and each bit i moves to bit i+1. The old top bit is dropped.
- R4: modeSel=2'b10 (shift down): at the rising edge, serInLeft enters bit WIDTH-1, and each bit i moves to bit i-1. The old bit 0 is dropped.
- R5: modeSel=2'b00 (hold): the register keeps its value across rising edges.
- R6: The block releases dataBus (high impedance) whenever oeAN or oeBN is high.
- R7: The block also releases dataBus whenever modeSel=2'b11. In every other case, with oeAN and oeBN both low, it drives the register value onto dataBus.
- R8: Loading, shifting, holding and reset work the same while the bus drivers are off. Re-enabling the drivers shows the updated value.
- R9: serOutLow always equals register bit 0, and serOutHigh always equals bit WIDTH-1, whatever the enables are.
- R10: After rstN goes high, the first rising edge applies the selected mode to the all-zero register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous clear, active low |
| modeSel | input | 2 | 00 hold, 01 shift up, 10 shift down, 11 load |
| serInRight | input | 1 | Serial bit that enters bit 0 on a shift up |
| serInLeft | input | 1 | Serial bit that enters the top bit on a shift down |
| oeAN | input | 1 | Bus driver enable A, active low |
| oeBN | input | 1 | Bus driver enable B, active low |
| dataBus | inout | WIDTH | Shared parallel data: register value out, load data in |
| serOutLow | output | 1 | Register bit 0 |
| serOutHigh | output | 1 | Register bit WIDTH-1 |

## Verification
Load, shift and hold results become visible one register stage after the edge that applies them. The scoreboard monitor therefore compares serial outputs and bus contents 1 ns after each rising edge, against the item the driver queued for that edge. Reset does not wait for a clock, so its check samples 1 ns after rstN falls, with no edge in between. The bus driver state follows the mode select and enables through logic alone. Its expected value is taken in the same post-edge sample, because inputs only change on falling edges.

// File: rtl/usr_shift_pkg.sv
package usr_shift_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } modeT;

  typedef struct packed {
    logic load;
    logic up;
    logic down;
    logic busEn;
  } strobeT;
endpackage

// File: rtl/usr_shift_ctrl.sv
module usr_shift_ctrl
  import usr_shift_pkg::*;
(
  input  logic [1:0] modeSel,
  input  logic       oeAN,
  input  logic       oeBN,
  output strobeT     strb
);
  modeT mode;
  assign mode = modeT'(modeSel);

  always_comb begin
    strb = '0;
    case (mode)
      MODE_UP:   strb.up   = 1'b1;
      MODE_DOWN: strb.down = 1'b1;
      MODE_LOAD: strb.load = 1'b1;
      default:   ;
    endcase
    // load mode frees the bus for the external source
    strb.busEn = !oeAN && !oeBN && (mode != MODE_LOAD);
  end
endmodule

// File: rtl/usr_shift_dp.sv
module usr_shift_dp
  import usr_shift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strb,
  input  logic             serInRight,
  input  logic             serInLeft,
  input  logic [WIDTH-1:0] busIn,
  output logic [WIDTH-1:0] q
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] nextQ;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic fromLower;
    logic fromUpper;
    if (i == 0) begin : g_lo
      assign fromLower = serInRight;
    end else begin : g_lo
      assign fromLower = q[i-1];
    end
    if (i == TOP) begin : g_hi
      assign fromUpper = serInLeft;
    end else begin : g_hi
      assign fromUpper = q[i+1];
    end
    always_comb begin
      if (strb.load)      nextQ[i] = busIn[i];
      else if (strb.up)   nextQ[i] = fromLower;
      else if (strb.down) nextQ[i] = fromUpper;
      else                nextQ[i] = q[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= '0;
    else       q <= nextQ;
  end

  always @(posedge clk) begin
    if (!rstN) p_reset_clear_r1: assert (q == '0);
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> q == $past(busIn));
  p_up_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.up |=> (q[0] == $past(serInRight)) && (q[TOP:1] == $past(q[TOP-1:0])));
  p_down_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.down |=> (q[TOP] == $past(serInLeft)) && (q[TOP-1:0] == $past(q[TOP:1])));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.load || strb.up || strb.down) |=> $stable(q));
  p_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.up, strb.down}));
endmodule

// File: rtl/usr_shift_top.sv
module usr_shift_top
  import usr_shift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic             serInRight,
  input  logic             serInLeft,
  input  logic             oeAN,
  input  logic             oeBN,
  inout  wire  [WIDTH-1:0] dataBus,
  output logic             serOutLow,
  output logic             serOutHigh
);
  strobeT           strb;
  logic [WIDTH-1:0] q;

  usr_shift_ctrl u_ctrl (
    .modeSel(modeSel),
    .oeAN(oeAN),
    .oeBN(oeBN),
    .strb(strb)
  );

  usr_shift_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .serInRight(serInRight),
    .serInLeft(serInLeft),
    .busIn(dataBus),
    .q(q)
  );

  assign dataBus    = strb.busEn ? q : {WIDTH{1'bz}};
  assign serOutLow  = q[0];
  assign serOutHigh = q[WIDTH-1];

  p_oe_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    (oeAN || oeBN) |-> !strb.busEn);
  p_load_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b11) |-> !strb.busEn);
  p_drive_on_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!oeAN && !oeBN && modeSel != 2'b11) |-> (dataBus == q));
  p_serial_r9: assert property (@(posedge clk) disable iff (!rstN)
    (serOutLow == q[0]) && (serOutHigh == q[WIDTH-1]));
endmodule

// File: tb/usr_shift_top_test.sv
module usr_shift_top_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [1:0]   modeSel = 2'b00;
  logic         serInRight = 1'b0;
  logic         serInLeft = 1'b0;
  logic         oeAN = 1'b0;
  logic         oeBN = 1'b0;
  logic         tbDrive = 1'b0;
  logic [W-1:0] tbVal = '0;
  wire  [W-1:0] busWire;
  logic         serOutLow;
  logic         serOutHigh;

  int checks = 0;
  int fails = 0;
  logic [W-1:0] model = '0;

  typedef struct {
    logic [W-1:0] q;
    logic         drive;
    logic         tbDrv;
    logic [W-1:0] tbV;
    string        tag;
  } itemT;
  itemT sb[$];

  always #2 clk = ~clk;

  assign busWire = tbDrive ? tbVal : {W{1'bz}};

  usr_shift_top #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel),
    .serInRight(serInRight), .serInLeft(serInLeft),
    .oeAN(oeAN), .oeBN(oeBN), .dataBus(busWire),
    .serOutLow(serOutLow), .serOutHigh(serOutHigh)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic sr, input logic sl,
                      input logic oa, input logic ob, input logic td,
                      input logic [W-1:0] tv, input string tag);
    itemT it;
    @(negedge clk);
    modeSel = m; serInRight = sr; serInLeft = sl;
    oeAN = oa; oeBN = ob; tbDrive = td; tbVal = tv;
    @(posedge clk);
    case (m)
      2'b11: model = tv;
      2'b01: model = {model[W-2:0], sr};
      2'b10: model = {sl, model[W-1:1]};
      default: ;
    endcase
    it.q = model;
    it.drive = !oa && !ob && (m != 2'b11);
    it.tbDrv = td;
    it.tbV = tv;
    it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin : monitor
    itemT it;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        check({it.tag, " R9 serOutLow"}, {{(W-1){1'b0}}, serOutLow}, {{(W-1){1'b0}}, it.q[0]});
        check({it.tag, " R9 serOutHigh"}, {{(W-1){1'b0}}, serOutHigh}, {{(W-1){1'b0}}, it.q[W-1]});
        if (it.drive)      check({it.tag, " R7 bus drive"}, busWire, it.q);
        else if (it.tbDrv) check({it.tag, " R6 bus released"}, busWire, it.tbV);
      end
    end
  end

  initial begin : watchdog
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: reset holds register at zero even with edges and load mode
    #1;
    check("R1 reset bus", busWire, '0);
    @(negedge clk); modeSel = 2'b11; tbDrive = 1'b1; tbVal = 8'hAA;
    repeat (3) @(posedge clk);
    @(negedge clk); tbDrive = 1'b0; modeSel = 2'b00; #1;
    check("R1 reset overrides load", busWire, '0);
    check("R1 reset serial", {6'd0, serOutHigh, serOutLow}, 8'h00);
    rstN = 1'b1;

    // R10: first edge after release applies mode to zero contents
    step(2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R10 first shift");
    step(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, "R2 load A5");
    step(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R2 R5 after load");
    for (int i = 0; i < 4; i++)
      step(2'b01, i[0], 1'b0, 1'b0, 1'b0, 1'b0, '0, "R3 shift up");
    for (int i = 0; i < 5; i++)
      step(2'b10, 1'b0, ~i[1], 1'b0, 1'b0, 1'b0, '0, "R4 shift down");
    for (int i = 0; i < 3; i++)
      step(2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R5 hold");
    step(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h80, "R2 load 80");
    for (int i = 0; i < 8; i++)
      step(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R4 walk down");
    step(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01, "R2 load 01");
    for (int i = 0; i < 8; i++)
      step(2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R3 fill up");

    // R6 / R8: drivers off via either enable, register keeps working
    step(2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h3C, "R6 oeA high");
    step(2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hC3, "R6 R8 oeB high shift");
    step(2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h5A, "R6 R8 both high shift");
    step(2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h96, "R8 load while off");
    step(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R8 re-enable shows value");
    step(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h69, "R7 load releases bus");
    step(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R7 hold drives");

    // R1: asynchronous reset mid-run, checked without a clock edge
    @(negedge clk);
    modeSel = 2'b00; oeAN = 1'b0; oeBN = 1'b0; tbDrive = 1'b0;
    rstN = 1'b0;
    #1;
    check("R1 async clear bus", busWire, '0);
    check("R1 async clear serial", {6'd0, serOutHigh, serOutLow}, 8'h00);
    model = '0;
    @(negedge clk); rstN = 1'b1;
    step(2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R10 shift down after reset");
    step(2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0, "R8 hold while off");
    step(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R5 final hold");

    repeat (3) @(posedge clk);
    #2;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule